// File: doc/BRIEF.md
# Multi-Track Deskew Output Register

This block collects one bit per tape track while a character is read in parallel. The tracks of a character arrive at slightly different times. Each track pulse is held in a storage flip-flop for that track. A common transfer strobe then copies every stored bit into an output register in the same clock, so the whole character appears on the output at once. The same strobe empties the storage stage so it is ready for the next character. The track count is a parameter and defaults to 9.

The parallel output is gated by an output qualifier that the block produces itself. After the run-normal status asserts, a ramp-up counter counts character-rate ticks and saturates at a parameterised limit, which defaults to 128. The qualifier is true only when the counter has reached that limit and all of the following hold: not busy, not at load point, unit selected, and run-normal true. While the qualifier is false, the parallel output reads as all zeros. All inputs are synchronous, and each track pulse and each strobe lasts one clock.

Top module: `trk_deskew_reg`

## Requirements
- R1: A pulse on track bit i, in a cycle without a strobe, sets that track's storage bit. The bit stays set until the next strobe. Pulses on other tracks leave it unchanged.
- R2: On a strobe cycle, every bit of the output register loads the storage value that was held before that cycle, all in the same clock.
- R3: A strobe empties the storage stage. A track pulse that arrives in the strobe cycle itself is not part of the character being transferred. It is kept in storage for the next character.
- R4: While `out_enable` is 0, `data_out` is all zeros. While `out_enable` is 1, `data_out` equals the output register.
- R5: `out_enable` can be 1 only when `busy`=0, `load_point`=0, `select1`=1 and `run_normal`=1.
- R6: While `run_normal` is 0, the ramp counter is held at 0. While `run_normal` is 1, the counter advances once per cycle in which `char_tick`=1, and it stops at RAMP_COUNT. `out_enable` stays 0 until the counter has reached RAMP_COUNT.
- R7: Between strobes, the output register holds its value, no matter what track pulses arrive.
- R8: A synchronous reset (`rst`=1) clears the storage, the output register and the ramp counter. As a result, `data_out` is 0 and `out_enable` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| trk_pulse | input | TRACKS | One-clock detection pulse per track |
| xfer_strobe | input | 1 | One-clock transfer strobe |
| char_tick | input | 1 | Character-rate enable for the ramp counter |
| run_normal | input | 1 | Synchronous motion running |
| busy | input | 1 | Transport busy status |
| load_point | input | 1 | Tape at load point status |
| select1 | input | 1 | Unit selected and on line |
| data_out | output | TRACKS | Gated deskewed character |
| out_enable | output | 1 | Output qualifier after ramp-up |

## Verification
The bench uses a four-track, five-count configuration. Every 4-bit character is delivered with its low and high halves in separate cycles. This shows that the output is assembled only at the strobe and holds steady while the pulses arrive. A pulse placed exactly on the strobe cycle must appear only in the following character, which separates the correct clear-then-set order from an ordering that loses or leaks the bit. All eight busy/load-point/select combinations are swept with a nonzero character held in the output. Dropping and restoring run-normal, with the tick count stopped one short of the limit and then reaching it, shows whether the ramp counter was cleared and where its threshold lies.

// File: rtl/trk_pkg.sv
package trk_pkg;

   // Width of a counter that must reach the value lim inclusive.
   function automatic int cnt_bits(input int lim);
      int w;
      w = 1;
      while ((1 << w) <= lim) w++;
      return w;
   endfunction

   // Motion and selection status required before the output may open.
   function automatic logic status_ok(input logic busy_i, input logic lp_i,
                                      input logic sel_i, input logic run_i);
      return !busy_i && !lp_i && sel_i && run_i;
   endfunction

endpackage

// File: rtl/trk_capture_lane.sv
module trk_capture_lane (
   input  logic clk,
   input  logic rst,
   input  logic pulse,
   input  logic strobe,
   output logic out_bit
);

   logic store_q;
   logic out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         store_q <= 1'b0;
         out_q   <= 1'b0;
      end else if (strobe) begin
         out_q   <= store_q;
         store_q <= pulse;
      end else if (pulse) begin
         store_q <= 1'b1;
      end
   end

   assign out_bit = out_q;

   assert_set_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (pulse && !strobe) |=> store_q);

   assert_keep_until_strobe_R1: assert property (@(posedge clk) disable iff (rst)
      (store_q && !strobe) |=> store_q);

   assert_load_together_R2: assert property (@(posedge clk) disable iff (rst)
      strobe |=> (out_bit == $past(store_q)));

   assert_clear_retain_R3: assert property (@(posedge clk) disable iff (rst)
      strobe |=> (store_q == $past(pulse)));

   assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(out_bit));

endmodule

// File: rtl/trk_ramp_delay.sv
module trk_ramp_delay #(
   parameter int RAMP_COUNT = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic run_normal,
   input  logic char_tick,
   output logic ramp_done
);

   localparam int CW = trk_pkg::cnt_bits(RAMP_COUNT);
   localparam logic [CW-1:0] LIMIT = CW'(RAMP_COUNT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_normal) begin
         cnt_q <= '0;
      end else if (char_tick && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ramp_done = (cnt_q == LIMIT);

   assert_ramp_clear_R6: assert property (@(posedge clk) disable iff (rst)
      !run_normal |=> (cnt_q == '0));

   assert_ramp_cap_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q <= LIMIT));

   assert_ramp_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (run_normal && !char_tick) |=> $stable(cnt_q));

   assert_ramp_reset_R8: assert property (@(posedge clk)
      rst |=> (cnt_q == '0));

endmodule

// File: rtl/trk_deskew_reg.sv
module trk_deskew_reg #(
   parameter int TRACKS     = 9,
   parameter int RAMP_COUNT = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TRACKS-1:0] trk_pulse,
   input  logic              xfer_strobe,
   input  logic              char_tick,
   input  logic              run_normal,
   input  logic              busy,
   input  logic              load_point,
   input  logic              select1,
   output logic [TRACKS-1:0] data_out,
   output logic              out_enable
);

   if (TRACKS < 1) begin : g_bad_tracks
      $error("trk_deskew_reg: TRACKS must be at least 1");
   end
   if (RAMP_COUNT < 1) begin : g_bad_ramp
      $error("trk_deskew_reg: RAMP_COUNT must be at least 1");
   end

   logic [TRACKS-1:0] lane_out;
   logic              ramp_done;

   for (genvar t = 0; t < TRACKS; t++) begin : g_lane
      trk_capture_lane u_lane (
         .clk     (clk),
         .rst     (rst),
         .pulse   (trk_pulse[t]),
         .strobe  (xfer_strobe),
         .out_bit (lane_out[t])
      );
   end

   trk_ramp_delay #(
      .RAMP_COUNT (RAMP_COUNT)
   ) u_ramp (
      .clk        (clk),
      .rst        (rst),
      .run_normal (run_normal),
      .char_tick  (char_tick),
      .ramp_done  (ramp_done)
   );

   assign out_enable = ramp_done &&
                       trk_pkg::status_ok(busy, load_point, select1, run_normal);
   assign data_out   = out_enable ? lane_out : '0;

   assert_gate_zero_R4: assert property (@(posedge clk) disable iff (rst)
      !out_enable |-> (data_out == '0));

   assert_gate_pass_R4: assert property (@(posedge clk) disable iff (rst)
      out_enable |-> (data_out == lane_out));

   assert_enable_status_R5: assert property (@(posedge clk) disable iff (rst)
      out_enable |-> (!busy && !load_point && select1 && run_normal));

   assert_enable_ramp_R6: assert property (@(posedge clk) disable iff (rst)
      out_enable |-> ramp_done);

   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> ((lane_out == '0) && !ramp_done));

endmodule

// File: tb/trk_deskew_reg_bench.sv
module trk_deskew_reg_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NT   = 4;
   localparam int RAMP = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic [NT-1:0] trk_pulse;
   logic          xfer_strobe;
   logic          char_tick;
   logic          run_normal;
   logic          busy;
   logic          load_point;
   logic          select1;
   logic [NT-1:0] data_out;
   logic          out_enable;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   trk_deskew_reg #(.TRACKS(NT), .RAMP_COUNT(RAMP)) u_trk_deskew_reg (
      .clk(clk), .rst(rst), .trk_pulse(trk_pulse), .xfer_strobe(xfer_strobe),
      .char_tick(char_tick), .run_normal(run_normal), .busy(busy),
      .load_point(load_point), .select1(select1),
      .data_out(data_out), .out_enable(out_enable)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ticks_n(input int n);
      for (int k = 0; k < n; k++) begin
         char_tick = 1'b1; tick();
         char_tick = 1'b0; tick();
      end
   endtask

   task automatic send_char(input logic [NT-1:0] p, input logic [NT-1:0] prev);
      trk_pulse = p & 4'h3; tick();
      trk_pulse = p & 4'hC; tick();
      trk_pulse = '0;
      check("R7 output steady while pulses arrive", int'(data_out), int'(prev));
      xfer_strobe = 1'b1; tick();
      xfer_strobe = 1'b0;
      check("R1 R2 character transferred", int'(data_out), int'(p));
   endtask

   initial begin
      rst = 1'b1; trk_pulse = '0; xfer_strobe = 1'b0; char_tick = 1'b0;
      run_normal = 1'b0; busy = 1'b0; load_point = 1'b0; select1 = 1'b0;
      @(negedge clk);
      tick(); tick();
      rst = 1'b0;
      check("R8 data after reset", int'(data_out), 0);
      check("R8 enable after reset", int'(out_enable), 0);

      // ramp-up
      select1 = 1'b1; run_normal = 1'b1; tick();
      ticks_n(RAMP - 1);
      check("R6 enable before limit", int'(out_enable), 0);
      ticks_n(1);
      check("R6 enable at limit", int'(out_enable), 1);
      ticks_n(3);
      check("R6 enable after saturation", int'(out_enable), 1);

      // exhaustive characters
      begin
         logic [NT-1:0] prev;
         prev = '0;
         for (int p = 0; p < 16; p++) begin
            send_char(NT'(p), prev);
            prev = NT'(p);
         end
      end

      // storage emptied by strobe
      xfer_strobe = 1'b1; tick(); xfer_strobe = 1'b0;
      check("R3 storage cleared by strobe", int'(data_out), 0);

      // pulse on the strobe cycle goes to next character
      trk_pulse = 4'h5; tick();
      trk_pulse = 4'hA; xfer_strobe = 1'b1; tick();
      trk_pulse = '0; xfer_strobe = 1'b0;
      check("R3 strobe cycle pulse excluded", int'(data_out), 5);
      xfer_strobe = 1'b1; tick(); xfer_strobe = 1'b0;
      check("R3 strobe cycle pulse retained", int'(data_out), 10);

      // status sweep with output holding 4'hA
      for (int s = 0; s < 8; s++) begin
         logic en_exp;
         busy = s[0]; load_point = s[1]; select1 = s[2];
         tick();
         en_exp = !s[0] && !s[1] && s[2];
         check("R5 status gating", int'(out_enable), int'(en_exp));
         check("R4 gated output", int'(data_out), en_exp ? 10 : 0);
      end
      busy = 1'b0; load_point = 1'b0; select1 = 1'b1;

      // run-normal drop clears the ramp
      run_normal = 1'b0; tick();
      check("R5 enable with run low", int'(out_enable), 0);
      check("R4 data with run low", int'(data_out), 0);
      run_normal = 1'b1; tick();
      check("R6 counter cleared by run low", int'(out_enable), 0);
      ticks_n(RAMP - 1);
      check("R6 second ramp before limit", int'(out_enable), 0);
      ticks_n(1);
      check("R6 second ramp at limit", int'(out_enable), 1);
      check("R7 output held across ramp", int'(data_out), 10);

      // reset in operation
      trk_pulse = 4'hF; tick(); trk_pulse = '0;
      rst = 1'b1; tick(); rst = 1'b0;
      check("R8 data after mid reset", int'(data_out), 0);
      check("R8 enable after mid reset", int'(out_enable), 0);
      ticks_n(RAMP);
      xfer_strobe = 1'b1; tick(); xfer_strobe = 1'b0;
      check("R8 storage cleared by reset", int'(data_out), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule